// File: doc/BRIEF.md
# External Bus Acknowledge Timeout Monitor

This block guards external bus transfers whose length is set by an acknowledge driven from outside the chip, not by an internal wait-state count. When a transfer beat starts and its address matched no chip-select region, the monitor loads a programmable 8-bit limit and counts external bus clock cycles. If no acknowledge arrives in time, it ends the stuck transfer with an error-terminate pulse and latches a sticky timeout flag. Software clears the flag by writing one to it.

The block runs on the system clock. A bus clock enable marks the system cycles that are external bus clock edges, so every count is in bus cycles. With a bus clock divider of 2 or 4, the real-time timeout grows by that factor while the programmed limit stays the same. The register decode that supplies the enable bit, the limit and the clear strobe lives outside this block.

Top module: `bus_tmo_mon`

## Requirements
- R1: While reset is asserted, and right after it is released, `err_term` and `tmo_flag` are 0.
- R2: While `mon_en` is 0 no timeout is raised. Clearing `mon_en` while a beat is being timed drops that beat, so no error follows.
- R3: A beat that starts with `cs_hit` = 1 is never timed and never produces an error.
- R4: A beat starts on a bus edge (`bus_ce` = 1) with `xfer_start` = 1 and `cs_hit` = 0. With limit N it times out at bus edge N+1 after the start edge if `xfer_ack` was 0 on every one of bus edges 1 to N+1. A limit of 0 times out at the first bus edge after the start.
- R5: An acknowledge on any bus edge from 1 to N+1 ends the beat without error. This includes edge N+1, where the acknowledge wins over the timeout.
- R6: On a timeout, `err_term` goes to 1 at the timeout edge and stays 1 for exactly one bus cycle, until the next bus edge. `err_term` changes only on bus edges.
- R7: Counting advances only on bus edges. With one bus edge every D system cycles, `err_term` rises 1 + (N+1)·D system cycles after the cycle in which the start was presented, and it stays high for D system cycles.
- R8: A new start on a bus edge while a beat is being timed reloads the limit, and timing restarts from that edge.
- R9: Every timeout sets `tmo_flag`, which stays set until it is cleared.
- R10: A one-cycle `flag_clr` pulse clears `tmo_flag`. If a timeout occurs in the same cycle as the clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_ce | input | 1 | High in system cycles that are external bus clock edges |
| mon_en | input | 1 | Monitor enable |
| tmo_limit | input | 8 | Timeout limit N in bus cycles |
| xfer_start | input | 1 | Beat start strobe, sampled on bus edges |
| cs_hit | input | 1 | The starting beat matched a chip-select region |
| xfer_ack | input | 1 | Externally driven transfer acknowledge, sampled on bus edges |
| flag_clr | input | 1 | Write-one-to-clear strobe for the timeout flag |
| err_term | output | 1 | Error-terminate, high for one bus cycle after a timeout |
| tmo_flag | output | 1 | Sticky timeout flag |

## Verification
The assertions assume three things about the inputs. `bus_ce` is a steady periodic enable. `flag_clr` is a single-cycle pulse. Starts, acknowledges and enable changes are sampled only at clock edges and are stable between them. The stimulus changes every input on the falling clock edge. It changes the bus clock divider only while no beat is being timed, holds each start and acknowledge for exactly one bus edge, and issues the clear strobes while the divider is 1.

// File: rtl/bus_tmo_pkg.sv
package bus_tmo_pkg;

  localparam int unsigned TMO_W_DEF = 8;

  typedef enum logic [0:0] {
    MON_IDLE = 1'b0,
    MON_WAIT = 1'b1
  } mon_state_e;

endpackage

// File: rtl/tmo_rst_sync.sv
module tmo_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/tmo_down_cnt.sv
module tmo_down_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = load | step;
    if (load)      cnt_d = load_val;
    else if (step) cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/tmo_beat_ctrl.sv
module tmo_beat_ctrl
  import bus_tmo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bus_ce,
  input  logic mon_en,
  input  logic xfer_start,
  input  logic cs_hit,
  input  logic xfer_ack,
  input  logic cnt_zero,
  output logic cnt_load,
  output logic cnt_step,
  output logic tmo_evt
);

  mon_state_e state_q;
  mon_state_e state_d;
  logic       beat_go;

  assign beat_go = xfer_start & ~cs_hit;

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_step = 1'b0;
    tmo_evt  = 1'b0;
    if (!mon_en) begin
      state_d = MON_IDLE;
    end else if (bus_ce) begin
      if (beat_go) begin
        state_d  = MON_WAIT;
        cnt_load = 1'b1;
      end else if (state_q == MON_WAIT) begin
        if (xfer_ack) begin
          state_d = MON_IDLE;
        end else if (cnt_zero) begin
          state_d = MON_IDLE;
          tmo_evt = 1'b1;
        end else begin
          cnt_step = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MON_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/tmo_err_stat.sv
module tmo_err_stat (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_ce,
  input  logic tmo_evt,
  input  logic flag_clr,
  output logic err_term,
  output logic tmo_flag
);

  logic err_q, err_d;
  logic flag_q, flag_d;

  always_comb begin
    err_d = err_q;
    if (bus_ce) err_d = tmo_evt;
    flag_d = tmo_evt | (flag_q & ~flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      err_q  <= err_d;
      flag_q <= flag_d;
    end
  end

  assign err_term = err_q;
  assign tmo_flag = flag_q;

endmodule

// File: rtl/bus_tmo_mon.sv
module bus_tmo_mon
  import bus_tmo_pkg::*;
#(
  parameter int unsigned TMO_W = TMO_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_ce,
  input  logic             mon_en,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             xfer_start,
  input  logic             cs_hit,
  input  logic             xfer_ack,
  input  logic             flag_clr,
  output logic             err_term,
  output logic             tmo_flag
);

  localparam int unsigned SYNC_STAGES = 2;

  logic rst_core_n;
  logic cnt_load;
  logic cnt_step;
  logic cnt_zero;
  logic tmo_evt;

  tmo_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  tmo_beat_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .bus_ce     (bus_ce),
    .mon_en     (mon_en),
    .xfer_start (xfer_start),
    .cs_hit     (cs_hit),
    .xfer_ack   (xfer_ack),
    .cnt_zero   (cnt_zero),
    .cnt_load   (cnt_load),
    .cnt_step   (cnt_step),
    .tmo_evt    (tmo_evt)
  );

  tmo_down_cnt #(.W(TMO_W)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (cnt_load),
    .step     (cnt_step),
    .load_val (tmo_limit),
    .zero     (cnt_zero)
  );

  tmo_err_stat i_stat (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .bus_ce   (bus_ce),
    .tmo_evt  (tmo_evt),
    .flag_clr (flag_clr),
    .err_term (err_term),
    .tmo_flag (tmo_flag)
  );

endmodule

// File: rtl/bus_tmo_mon_chk.sv
module bus_tmo_mon_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_ce,
  input logic mon_en,
  input logic xfer_ack,
  input logic flag_clr,
  input logic tmo_evt,
  input logic err_term,
  input logic tmo_flag
);

  // R2
  disabled_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |=> !$rose(err_term));

  // R5
  ack_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ce && xfer_ack) |=> !$rose(err_term));

  // R6
  err_on_bus_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ce |=> $stable(err_term));

  // R6
  err_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_term && bus_ce && !tmo_evt) |=> !err_term);

  // R9
  tmo_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> (tmo_flag && err_term));

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !flag_clr) |=> tmo_flag);

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !tmo_evt) |=> !tmo_flag);

endmodule

bind bus_tmo_mon bus_tmo_mon_chk i_bus_tmo_mon_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_ce   (bus_ce),
  .mon_en   (mon_en),
  .xfer_ack (xfer_ack),
  .flag_clr (flag_clr),
  .tmo_evt  (tmo_evt),
  .err_term (err_term),
  .tmo_flag (tmo_flag)
);

// File: tb/test_bus_tmo_mon.sv
module test_bus_tmo_mon;

  localparam time CLK_PER = 8ns;

  typedef struct {
    bit    err;
    int    lat;
    int    wid;
    bit    flag;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_ce;
  logic       mon_en;
  logic [7:0] tmo_limit;
  logic       xfer_start;
  logic       cs_hit;
  logic       xfer_ack;
  logic       flag_clr;
  logic       err_term;
  logic       tmo_flag;

  int   n_checks = 0;
  int   n_errors = 0;
  int   cyc = 0;
  int   div = 1;
  int   div_cnt = 0;
  int   start_cyc = 0;
  bit   seen = 0;
  int   first_cyc = 0;
  int   wid = 0;
  bit   done = 0;
  exp_t sb_q[$];
  event done_ev;

  always #(CLK_PER/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    div_cnt <= (div_cnt >= div - 1) ? 0 : div_cnt + 1;
  end
  assign bus_ce = (div_cnt == 0);

  bus_tmo_mon i_bus_tmo_mon (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_ce     (bus_ce),
    .mon_en     (mon_en),
    .tmo_limit  (tmo_limit),
    .xfer_start (xfer_start),
    .cs_hit     (cs_hit),
    .xfer_ack   (xfer_ack),
    .flag_clr   (flag_clr),
    .err_term   (err_term),
    .tmo_flag   (tmo_flag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // returns at the falling edge just before a bus-edge rising clock
  task automatic next_bus_edge();
    @(negedge clk);
    while (!bus_ce) @(negedge clk);
  endtask

  // monitor: observe err_term away from the active edge
  always @(negedge clk) begin
    if (err_term) begin
      if (!seen) first_cyc = cyc;
      seen = 1'b1;
      wid  = wid + 1;
    end
  end

  initial begin
    forever begin
      @(done_ev);
      begin
        exp_t it;
        it = sb_q.pop_front();
        check(seen == it.err, it.tag, "error raised", int'(seen), int'(it.err));
        if (it.err && seen) begin
          check(first_cyc - start_cyc == it.lat, it.tag, "error latency",
                first_cyc - start_cyc, it.lat);
          check(wid == it.wid, it.tag, "error width", wid, it.wid);
        end
        check(tmo_flag == it.flag, it.tag, "flag", int'(tmo_flag), int'(it.flag));
        seen = 1'b0;
        wid  = 0;
      end
    end
  end

  // driver: one monitored beat, expectations computed from the requirements
  task automatic beat(input int lim, input bit cs, input bit en, input int ack_at,
                      input int restart_at, input int drop_at, input int clr_at,
                      input bit flag_exp, input string tag);
    exp_t it;
    int   s;
    int   dead;
    bit   acked;
    bit   dropped;
    s       = restart_at;
    dead    = s + lim + 1;
    acked   = (ack_at > s) && (ack_at <= dead);
    dropped = (drop_at > 0) && (drop_at <= dead);
    it.err  = !cs && en && !acked && !dropped;
    it.lat  = 1 + dead * div;
    it.wid  = div;
    it.flag = flag_exp;
    it.tag  = tag;
    sb_q.push_back(it);
    next_bus_edge();
    start_cyc  = cyc;
    tmo_limit  = 8'(lim);
    mon_en     = en;
    cs_hit     = cs;
    xfer_start = 1'b1;
    for (int e = 1; e <= dead + 2; e++) begin
      next_bus_edge();
      xfer_start = (e == restart_at);
      cs_hit     = 1'b0;
      xfer_ack   = (e == ack_at);
      mon_en     = en && (e != drop_at);
      flag_clr   = (e == clr_at);
    end
    next_bus_edge();
    xfer_ack = 1'b0;
    flag_clr = 1'b0;
    mon_en   = 1'b1;
    next_bus_edge();
    next_bus_edge();
    -> done_ev;
    #1;
  endtask

  task automatic clear_flag(input string tag);
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    @(negedge clk);
    check(tmo_flag == 1'b0, tag, "flag after clear", int'(tmo_flag), 0);
  endtask

  initial begin
    rst_n      = 1'b0;
    mon_en     = 1'b1;
    tmo_limit  = 8'd5;
    xfer_start = 1'b0;
    cs_hit     = 1'b0;
    xfer_ack   = 1'b0;
    flag_clr   = 1'b0;
    repeat (3) @(negedge clk);
    check(err_term == 1'b0, "R1", "err_term in reset", int'(err_term), 0);
    check(tmo_flag == 1'b0, "R1", "tmo_flag in reset", int'(tmo_flag), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(err_term == 1'b0, "R1", "err_term after reset", int'(err_term), 0);
    check(tmo_flag == 1'b0, "R1", "tmo_flag after reset", int'(tmo_flag), 0);

    beat(5, 0, 1, 3, 0, 0, 0, 0, "R5 early ack");
    beat(5, 0, 1, 0, 0, 0, 0, 1, "R4 no ack");
    beat(5, 0, 1, 2, 0, 0, 0, 1, "R9 flag sticky");
    clear_flag("R10");
    beat(5, 0, 1, 6, 0, 0, 0, 0, "R5 ack on timeout edge");
    beat(5, 0, 1, 7, 0, 0, 0, 1, "R4 ack too late");
    beat(5, 0, 1, 0, 0, 0, 6, 1, "R10 clear with timeout");
    clear_flag("R10");
    beat(5, 1, 1, 0, 0, 0, 0, 0, "R3 chip-select hit");
    beat(5, 0, 0, 0, 0, 0, 0, 0, "R2 disabled");
    beat(3, 0, 1, 0, 0, 2, 0, 0, "R2 enable dropped");
    beat(0, 0, 1, 0, 0, 0, 0, 1, "R4 limit zero");
    clear_flag("R10");
    beat(3, 0, 1, 0, 2, 0, 0, 1, "R8 restart reload");
    clear_flag("R10");
    beat(255, 0, 1, 0, 0, 0, 0, 1, "R4 limit max");
    div = 2;
    beat(4, 0, 1, 0, 0, 0, 0, 1, "R7 divide by 2");
    beat(4, 0, 1, 5, 0, 0, 0, 1, "R5 divide by 2 ack");
    div = 4;
    beat(4, 0, 1, 0, 0, 0, 0, 1, "R6 divide by 4");
    beat(2, 0, 1, 0, 1, 0, 0, 1, "R8 divide by 4 restart");
    div = 1;
    repeat (4) @(negedge clk);
    clear_flag("R10");
    check(sb_q.size() == 0, "R4", "scoreboard drained", sb_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_PER * 200000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL R4 watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule